// File: doc/BRIEF.md
# Burst-Interleaved Banked Operand Register File

This block stores source operands for four thread batches in a register file split into independent banks, and gathers them into per-batch operand slots for an execution stage. Each bank row holds one word per batch. The word for batch k sits at burst position k. One bank read therefore returns the same logical register for all four batches at once. Each bank accepts at most one row address per clock. One clock of this block is one slow (T) clock.

Read requests arrive on two valid/ready ports. Each request carries a batch id, a register number and a destination operand position. Requests wait in a shared age-ordered queue. An arbiter grants each bank to the oldest waiting register that maps to it. Every waiting request that names the same register, for any batch or operand position, is served by that one burst. A request that loses a bank to a different register stays queued for a later clock.

The collector keeps three source operands per batch, each with a valid bit. It raises a per-batch ready flag once all three are present. The consumer pulses a per-batch retire input to empty a slot. A single write port loads register contents.

Top module: `burst_operand_rf`

## Requirements
- R1: After reset, no batch is ready, every operand word reads 0, and every request port is ready.
- R2: The register number selects the bank with its low 4 bits and the row with its upper 2 bits. Burst position k of a row holds batch k's word. A request (batch b, register r, operand s) loads the word last written to (r, b) into operand s of batch b.
- R3: A request accepted at clock edge E that meets no conflict updates the collector outputs at edge E+1.
- R4: When waiting requests name different registers in the same bank, only the oldest one's register is read in that clock. The others stay queued in age order and are retried on later clocks.
- R5: All waiting requests that name the register being read in a bank are served in that same clock, whatever their batch or operand position.
- R6: batchReady[b] is 1 exactly when all three operands of batch b are valid. Operand s of batch b appears on opData bits [(b*3+s)*16 +: 16].
- R7: A retire pulse for batch b clears its three valid bits at the next edge. A fill landing on the same edge still sets its own bit.
- R8: The queue holds 8 requests. Port p is ready when the occupancy at the start of the clock plus p is below 8. Accepted requests are placed after the waiting ones, port 0 before port 1.
- R9: A write stores its word at the clock edge. A read of the same register in the same clock returns the previous word.
- R10: A fill into an already valid operand replaces its data. When several requests served in one clock target the same operand, the one that entered the queue last wins. Operand codes of 3 or more fill nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T period per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 2 | Request valid, one bit per port |
| reqReady | output | 2 | Request accepted this clock, one bit per port |
| reqBatch | input | 4 | Batch id per port, 2 bits each |
| reqReg | input | 12 | Register number per port, 6 bits each |
| reqSrc | input | 4 | Destination operand position per port, 2 bits each |
| wrEn | input | 1 | Register write strobe |
| wrReg | input | 6 | Register number to write |
| wrBatch | input | 2 | Batch word (burst position) to write |
| wrData | input | 16 | Write data |
| batchRetire | input | 4 | Per-batch slot clear |
| batchReady | output | 4 | Per-batch operand set complete |
| opData | output | 192 | Collected operands, 4 batches x 3 operands x 16 bits |

## Verification
A single isolated request shows the register layout and the one-clock service latency. A pair of requests to different registers of the same bank separates serialization from coalescing. A pair to the same register from two batches shows that one burst serves both. Two requests filling one operand in the same clock settle which one wins. A queue flooded with requests that all map to bank 0 exercises backpressure on the second port before the first. Retire pulses that coincide with fills, and writes that coincide with reads, probe the edge ordering. A long random mix over a small register pool, which forces frequent coalescing and conflicts, is then compared every clock against a behavioural model.

// File: rtl/opc_pkg.sv
package opc_pkg;
  parameter int NUM_BANKS     = 16;
  parameter int BURST_LEN     = 4;
  parameter int ROWS_PER_BANK = 4;
  parameter int DATA_W        = 16;
  parameter int NUM_SRC       = 3;
  parameter int QUEUE_DEPTH   = 8;
  parameter int NUM_PORTS     = 2;

  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int ROW_W   = $clog2(ROWS_PER_BANK);
  localparam int REG_W   = BANK_W + ROW_W;
  localparam int BATCH_W = $clog2(BURST_LEN);
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int CNT_W   = $clog2(QUEUE_DEPTH + 1);
  localparam int QIDX_W  = $clog2(QUEUE_DEPTH);

  typedef struct packed {
    logic [BATCH_W-1:0] batch;
    logic [REG_W-1:0]   regNum;
    logic [SRC_W-1:0]   src;
  } req_t;

  // strobes from control to datapath for one T clock
  typedef struct packed {
    logic [NUM_BANKS-1:0]                           rdEn;
    logic [NUM_BANKS-1:0][ROW_W-1:0]                rdRow;
    logic [BURST_LEN-1:0][NUM_SRC-1:0]              fillEn;
    logic [BURST_LEN-1:0][NUM_SRC-1:0][BANK_W-1:0]  fillBank;
  } strobe_t;
endpackage

// File: rtl/opc_ctrl.sv
module opc_ctrl
  import opc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] reqValid,
  input  req_t                 reqIn [NUM_PORTS],
  output logic [NUM_PORTS-1:0] reqReady,
  output strobe_t              strobes
);
  req_t                   qEnt [QUEUE_DEPTH];
  req_t                   nxt  [QUEUE_DEPTH];
  logic [CNT_W-1:0]       qCnt;
  logic [CNT_W-1:0]       nxtCnt;
  logic [QUEUE_DEPTH-1:0] served;
  logic [BANK_W-1:0]      bnk;
  logic [ROW_W-1:0]       rw;

  // admission: port p needs p+1 free entries counted at clock start
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++)
      reqReady[p] = ({1'b0, qCnt} + (CNT_W+1)'(p)) < (CNT_W+1)'(QUEUE_DEPTH);
  end

  // bank arbitration in age order with same-register coalescing
  always_comb begin
    strobes = '0;
    served  = '0;
    bnk     = '0;
    rw      = '0;
    for (int i = 0; i < QUEUE_DEPTH; i++) begin
      if (CNT_W'(i) < qCnt) begin
        bnk = qEnt[i].regNum[BANK_W-1:0];
        rw  = qEnt[i].regNum[REG_W-1:BANK_W];
        if (!strobes.rdEn[bnk]) begin
          strobes.rdEn[bnk]  = 1'b1;
          strobes.rdRow[bnk] = rw;
          served[i]          = 1'b1;
        end else if (strobes.rdRow[bnk] == rw) begin
          served[i] = 1'b1;
        end
        if (served[i] && ({1'b0, qEnt[i].src} < (SRC_W+1)'(NUM_SRC))) begin
          strobes.fillEn[qEnt[i].batch][qEnt[i].src]   = 1'b1;
          strobes.fillBank[qEnt[i].batch][qEnt[i].src] = bnk;
        end
      end
    end
  end

  // compaction: survivors keep order, then new requests in port order
  always_comb begin
    nxtCnt = '0;
    for (int i = 0; i < QUEUE_DEPTH; i++) nxt[i] = '0;
    for (int i = 0; i < QUEUE_DEPTH; i++) begin
      if ((CNT_W'(i) < qCnt) && !served[i]) begin
        nxt[nxtCnt[QIDX_W-1:0]] = qEnt[i];
        nxtCnt = nxtCnt + 1'b1;
      end
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (reqValid[p] && reqReady[p]) begin
        nxt[nxtCnt[QIDX_W-1:0]] = reqIn[p];
        nxtCnt = nxtCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCnt <= '0;
      for (int i = 0; i < QUEUE_DEPTH; i++) qEnt[i] <= '0;
    end else begin
      qCnt <= nxtCnt;
      for (int i = 0; i < QUEUE_DEPTH; i++) qEnt[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/opc_bank.sv
module opc_bank
  import opc_pkg::*;
(
  input  logic                              clk,
  input  logic                              wrEn,
  input  logic [ROW_W-1:0]                  wrRow,
  input  logic [BATCH_W-1:0]                wrLane,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic                              rdEn,
  input  logic [ROW_W-1:0]                  rdRow,
  output logic [BURST_LEN-1:0][DATA_W-1:0]  rdBurst
);
  logic [BURST_LEN-1:0][DATA_W-1:0] mem [ROWS_PER_BANK];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrRow][wrLane] <= wrData;
  end

  // one row per clock, the whole burst at once
  assign rdBurst = rdEn ? mem[rdRow] : '0;
endmodule

// File: rtl/opc_collector.sv
module opc_collector
  import opc_pkg::*;
(
  input  logic                                            clk,
  input  logic                                            rstN,
  input  logic [BURST_LEN-1:0][NUM_SRC-1:0]               fillEn,
  input  logic [BURST_LEN-1:0][NUM_SRC-1:0][BANK_W-1:0]   fillBank,
  input  logic [NUM_BANKS-1:0][BURST_LEN-1:0][DATA_W-1:0] burst,
  input  logic [BURST_LEN-1:0]                            batchRetire,
  output logic [BURST_LEN-1:0]                            batchReady,
  output logic [BURST_LEN-1:0][NUM_SRC-1:0][DATA_W-1:0]   opData
);
  logic [BURST_LEN-1:0][NUM_SRC-1:0] opValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opValid <= '0;
      opData  <= '0;
    end else begin
      for (int b = 0; b < BURST_LEN; b++) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (fillEn[b][s]) begin
            opValid[b][s] <= 1'b1;
            opData[b][s]  <= burst[fillBank[b][s]][b];
          end else if (batchRetire[b]) begin
            opValid[b][s] <= 1'b0;
          end
        end
      end
    end
  end

  generate
    for (genvar b = 0; b < BURST_LEN; b++) begin : g_rdy
      assign batchReady[b] = &opValid[b];
    end
  endgenerate
endmodule

// File: rtl/opc_datapath.sv
module opc_datapath
  import opc_pkg::*;
(
  input  logic                                          clk,
  input  logic                                          rstN,
  input  strobe_t                                       strobes,
  input  logic                                          wrEn,
  input  logic [REG_W-1:0]                              wrReg,
  input  logic [BATCH_W-1:0]                            wrBatch,
  input  logic [DATA_W-1:0]                             wrData,
  input  logic [BURST_LEN-1:0]                          batchRetire,
  output logic [BURST_LEN-1:0]                          batchReady,
  output logic [BURST_LEN-1:0][NUM_SRC-1:0][DATA_W-1:0] opData
);
  logic [NUM_BANKS-1:0][BURST_LEN-1:0][DATA_W-1:0] burst;

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      opc_bank u_bank (
        .clk     (clk),
        .wrEn    (wrEn && (wrReg[BANK_W-1:0] == BANK_W'(g))),
        .wrRow   (wrReg[REG_W-1:BANK_W]),
        .wrLane  (wrBatch),
        .wrData  (wrData),
        .rdEn    (strobes.rdEn[g]),
        .rdRow   (strobes.rdRow[g]),
        .rdBurst (burst[g])
      );
    end
  endgenerate

  opc_collector u_coll (
    .clk         (clk),
    .rstN        (rstN),
    .fillEn      (strobes.fillEn),
    .fillBank    (strobes.fillBank),
    .burst       (burst),
    .batchRetire (batchRetire),
    .batchReady  (batchReady),
    .opData      (opData)
  );
endmodule

// File: rtl/burst_operand_rf.sv
module burst_operand_rf
  import opc_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_PORTS-1:0]                  reqValid,
  output logic [NUM_PORTS-1:0]                  reqReady,
  input  logic [NUM_PORTS*BATCH_W-1:0]          reqBatch,
  input  logic [NUM_PORTS*REG_W-1:0]            reqReg,
  input  logic [NUM_PORTS*SRC_W-1:0]            reqSrc,
  input  logic                                  wrEn,
  input  logic [REG_W-1:0]                      wrReg,
  input  logic [BATCH_W-1:0]                    wrBatch,
  input  logic [DATA_W-1:0]                     wrData,
  input  logic [BURST_LEN-1:0]                  batchRetire,
  output logic [BURST_LEN-1:0]                  batchReady,
  output logic [BURST_LEN*NUM_SRC*DATA_W-1:0]   opData
);
  req_t    reqIn [NUM_PORTS];
  strobe_t strobes;
  logic [BURST_LEN-1:0][NUM_SRC-1:0][DATA_W-1:0] opArr;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
      assign reqIn[p].batch  = reqBatch[p*BATCH_W +: BATCH_W];
      assign reqIn[p].regNum = reqReg[p*REG_W +: REG_W];
      assign reqIn[p].src    = reqSrc[p*SRC_W +: SRC_W];
    end
  endgenerate

  opc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqIn    (reqIn),
    .reqReady (reqReady),
    .strobes  (strobes)
  );

  opc_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrEn        (wrEn),
    .wrReg       (wrReg),
    .wrBatch     (wrBatch),
    .wrData      (wrData),
    .batchRetire (batchRetire),
    .batchReady  (batchReady),
    .opData      (opArr)
  );

  assign opData = opArr;
endmodule

// File: rtl/burst_operand_rf_chk.sv
module burst_operand_rf_chk
  import opc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] reqValid,
  input logic [NUM_PORTS-1:0] reqReady,
  input logic [BURST_LEN-1:0] batchRetire,
  input logic [BURST_LEN-1:0] batchReady
);
  logic everAcc;

  always_ff @(posedge clk) begin
    if (!rstN) everAcc <= 1'b0;
    else if (|(reqValid & reqReady)) everAcc <= 1'b1;
  end

  // R1: nothing can be ready before the first accepted request
  a_r1_quiet_until_request: assert property (@(posedge clk) disable iff (!rstN)
    !everAcc |-> (batchReady == '0));

  generate
    for (genvar p = 1; p < NUM_PORTS; p++) begin : g_port
      // R8: a higher port is never ready while a lower one is not
      a_r8_port_order: assert property (@(posedge clk) disable iff (!rstN)
        reqReady[p] |-> reqReady[p-1]);
    end
    for (genvar b = 0; b < BURST_LEN; b++) begin : g_batch
      // R6: a complete slot stays complete until retired
      a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
        (batchReady[b] && !batchRetire[b]) |=> batchReady[b]);
      // R7: ready only drops after a retire pulse
      a_r7_drop_needs_retire: assert property (@(posedge clk) disable iff (!rstN)
        $fell(batchReady[b]) |-> $past(batchRetire[b]));
    end
  endgenerate
endmodule

bind burst_operand_rf burst_operand_rf_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .batchRetire (batchRetire),
  .batchReady  (batchReady)
);

// File: tb/tb_burst_operand_rf.sv
module tb_burst_operand_rf;
  import opc_pkg::*;

  logic clk = 1'b0;
  logic rstN;
  logic [NUM_PORTS-1:0]                reqValid;
  logic [NUM_PORTS-1:0]                reqReady;
  logic [NUM_PORTS*BATCH_W-1:0]        reqBatch;
  logic [NUM_PORTS*REG_W-1:0]          reqReg;
  logic [NUM_PORTS*SRC_W-1:0]          reqSrc;
  logic                                wrEn;
  logic [REG_W-1:0]                    wrReg;
  logic [BATCH_W-1:0]                  wrBatch;
  logic [DATA_W-1:0]                   wrData;
  logic [BURST_LEN-1:0]                batchRetire;
  logic [BURST_LEN-1:0]                batchReady;
  logic [BURST_LEN*NUM_SRC*DATA_W-1:0] opData;

  burst_operand_rf dut (.*);

  always #4 clk = ~clk;

  typedef struct {int b; int r; int s;} ent_t;
  ent_t q[$];
  int mMem [NUM_BANKS*ROWS_PER_BANK][BURST_LEN];
  int mData[BURST_LEN][NUM_SRC];
  bit mValid[BURST_LEN][NUM_SRC];
  int nComp = 0;
  int nMis = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nComp++;
    if (act != exp) begin
      nMis++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareOut(string tag);
    for (int b = 0; b < BURST_LEN; b++) begin
      chk(tag, $sformatf("batchReady[%0d]", b), int'(batchReady[b]),
          int'(mValid[b][0] && mValid[b][1] && mValid[b][2]));
      for (int s = 0; s < NUM_SRC; s++)
        chk(tag, $sformatf("opData[%0d][%0d]", b, s),
            int'(opData[(b*NUM_SRC+s)*DATA_W +: DATA_W]), mData[b][s]);
    end
  endtask

  task automatic setReq(int p, int b, int r, int s);
    reqValid[p] = 1'b1;
    reqBatch[p*BATCH_W +: BATCH_W] = BATCH_W'(b);
    reqReg[p*REG_W +: REG_W]       = REG_W'(r);
    reqSrc[p*SRC_W +: SRC_W]       = SRC_W'(s);
  endtask

  task automatic setWr(int r, int b, int d);
    wrEn = 1'b1; wrReg = REG_W'(r); wrBatch = BATCH_W'(b); wrData = DATA_W'(d);
  endtask

  // one T clock: check ready, advance the model, sample after the edge
  task automatic tick(string tag);
    int occ;
    int cl[NUM_BANKS];
    ent_t keep[$];
    #1;
    occ = q.size();
    for (int p = 0; p < NUM_PORTS; p++)
      chk(tag, $sformatf("reqReady[%0d]", p), int'(reqReady[p]), int'(occ + p < QUEUE_DEPTH));
    for (int b = 0; b < BURST_LEN; b++)
      if (batchRetire[b]) for (int s = 0; s < NUM_SRC; s++) mValid[b][s] = 0;
    foreach (cl[i]) cl[i] = -1;
    foreach (q[i]) begin
      int bk = q[i].r % NUM_BANKS;
      int rw = q[i].r / NUM_BANKS;
      bit sv = 0;
      if (cl[bk] < 0) begin cl[bk] = rw; sv = 1; end
      else if (cl[bk] == rw) sv = 1;
      if (sv) begin
        if (q[i].s < NUM_SRC) begin
          mValid[q[i].b][q[i].s] = 1;
          mData[q[i].b][q[i].s]  = mMem[q[i].r][q[i].b];
        end
      end else keep.push_back(q[i]);
    end
    for (int p = 0; p < NUM_PORTS; p++)
      if (reqValid[p] && (occ + p < QUEUE_DEPTH)) begin
        ent_t e;
        e.b = int'(reqBatch[p*BATCH_W +: BATCH_W]);
        e.r = int'(reqReg[p*REG_W +: REG_W]);
        e.s = int'(reqSrc[p*SRC_W +: SRC_W]);
        keep.push_back(e);
      end
    if (wrEn) mMem[wrReg][wrBatch] = int'(wrData);
    q = keep;
    @(posedge clk);
    @(negedge clk);
    compareOut(tag);
    reqValid = '0; wrEn = 1'b0; batchRetire = '0;
  endtask

  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nMis++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nComp, nMis);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = '0; reqBatch = '0; reqReg = '0; reqSrc = '0;
    wrEn = 1'b0; wrReg = '0; wrBatch = '0; wrData = '0; batchRetire = '0;
    foreach (mData[b, s]) begin mData[b][s] = 0; mValid[b][s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    compareOut("R1");
    for (int p = 0; p < NUM_PORTS; p++)
      chk("R1", $sformatf("reqReady[%0d]", p), int'(reqReady[p]), 1);

    // R9: load every register word through the write port
    for (int r = 0; r < NUM_BANKS*ROWS_PER_BANK; r++)
      for (int b = 0; b < BURST_LEN; b++) begin
        setWr(r, b, (r*BURST_LEN + b)*37 + 11);
        tick("R9");
      end

    // R2, R3: single request, visible one edge after acceptance
    setReq(0, 2, 37, 1); tick("R3");
    ticks("R2", 2);

    // R4: registers 5 and 21 share bank 5
    setReq(0, 0, 5, 0); setReq(1, 1, 21, 0); tick("R4");
    ticks("R4", 3);

    // R5: one burst of register 9 serves batches 0 and 3
    setReq(0, 0, 9, 2); setReq(1, 3, 9, 2); tick("R5");
    ticks("R5", 2);

    // R10: two fills into the same operand in one clock, port 1 wins
    setReq(0, 2, 3, 0); setReq(1, 2, 10, 0); tick("R10");
    ticks("R10", 2);
    setReq(0, 2, 60, 0); setReq(1, 2, 44, 3); tick("R10");
    ticks("R10", 2);

    // R6: complete batch 1
    setReq(0, 1, 40, 0); setReq(1, 1, 41, 1); tick("R6");
    setReq(0, 1, 42, 2); tick("R6");
    ticks("R6", 2);

    // R7: retire alone, then retire coinciding with a fill
    batchRetire[1] = 1'b1; tick("R7");
    setReq(0, 1, 50, 0); tick("R7");
    batchRetire[1] = 1'b1; tick("R7");
    ticks("R7", 2);

    // R9: write and read the same register in one clock
    setReq(0, 3, 12, 1); tick("R9");
    setWr(12, 3, 999); tick("R9");
    setReq(0, 3, 12, 2); tick("R9");
    ticks("R9", 2);

    // R8: flood bank 0 with four distinct rows
    for (int i = 0; i < 12; i++) begin
      setReq(0, i % 4, (i % 4) * 16, i % 3);
      setReq(1, (i + 1) % 4, ((i + 2) % 4) * 16, (i + 1) % 3);
      tick("R8");
    end
    ticks("R8", 12);

    // random mix over a small register pool
    for (int i = 0; i < 4000; i++) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if ($urandom % 3 != 0)
          setReq(p, $urandom % BURST_LEN, (($urandom % 4) * 16) + ($urandom % 3), $urandom % NUM_SRC);
      if ($urandom % 8 == 0) setWr($urandom % 64, $urandom % BURST_LEN, $urandom % 65536);
      for (int b = 0; b < BURST_LEN; b++)
        if ($urandom % 10 == 0) batchRetire[b] = 1'b1;
      tick("R5");
    end
    ticks("R4", 10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nComp, nMis);
    $finish;
  end
endmodule